// File: doc/BRIEF.md
# Radix-4 Twiddle Factor Generator

This block supplies the three non-trivial rotation factors that one radix-4 butterfly needs, W^k, W^2k and W^3k, for a transform whose length N is a power of four (N = 4096 by default). Each factor leaves the block as a cosine term and a sine term in signed Q1.15 two's-complement form. With the default width an output of 1.0 would be 32768, which cannot be represented, so the largest positive value is 32767. The factor W^0 is not produced, because the butterfly does not need it.

A twiddle index k and a valid strobe enter the block, and it can accept a new index on every clock cycle. The base factor is built from two small tables. A coarse table, addressed by the upper index bits, covers the full circle. A fine table, addressed by the lower bits, covers one coarse step. The two table results are combined with the angle-addition identities. The doubled factor is computed as cos 2θ = 2cos²θ − 1 and sin 2θ = 2·sinθ·cosθ. The tripled factor is computed by second-order recursion: cos 3θ = 2cosθ·cos2θ − cosθ and sin 3θ = 2cosθ·sin2θ − sinθ. A delay line aligns all three factors, so they appear together in one cycle under a single valid flag.

Top module: `twf_gen`

## Requirements
- R1: While reset is held, and for the first seven cycles after reset is released, `out_valid` is low. An index accepted at a rising clock edge has its three factors on the outputs, with `out_valid` high, just after the seventh rising edge that follows.
- R2: The W^k outputs stay within 3 LSB of cos(2πk/N) and sin(2πk/N). The reference value is the real value times 32768, rounded to nearest and clamped to [−32768, 32767].
- R3: The W^2k outputs stay within 12 LSB of the Q1.15 cosine and sine of 4πk/N, using the same rounding and clamping as R2.
- R4: The W^3k outputs stay within 32 LSB of the Q1.15 cosine and sine of 6πk/N, using the same rounding and clamping as R2.
- R5: For k = 0 all three cosine outputs stay above 32700 and all three sine outputs are within tolerance of 0. A result that reaches +1.0 saturates to 32767 and never wraps to a negative value.
- R6: Indices presented on consecutive cycles give results on consecutive cycles, in the same order, with no stall.
- R7: A cycle with `in_valid` low gives a cycle with `out_valid` low seven edges later, whatever `in_idx` held in that cycle.
- R8: The upper 6 bits of k select the coarse step and the lower 6 bits select the fine offset. Indices on either side of a coarse boundary (63, 64, 4032, 4095) meet the R2 to R4 bounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Index strobe |
| in_idx | input | IDX_W (12) | Twiddle index k |
| out_valid | output | 1 | Shared valid for all three factors |
| out_w1_cos | output | 16 | cos(θ), Q1.15 |
| out_w1_sin | output | 16 | sin(θ), Q1.15 |
| out_w2_cos | output | 16 | cos(2θ), Q1.15 |
| out_w2_sin | output | 16 | sin(2θ), Q1.15 |
| out_w3_cos | output | 16 | cos(3θ), Q1.15 |
| out_w3_sin | output | 16 | sin(3θ), Q1.15 |

## Verification
The latency and zero-index properties assume that `in_valid` is driven low and known for the whole of reset. They do not engage until seven clock edges after reset is released, so that the delayed strobe always refers to an index sampled outside reset. The unit-circle properties assume nothing about the index, since every 12-bit value addresses real table entries. The stimulus holds the strobe low during reset, always drives indices of exactly twelve bits, and mixes directed quadrant and coarse-boundary indices with seeded random indices, random gaps in the strobe, and junk index values during the gaps.

// File: rtl/twf_pkg.sv
package twf_pkg;

    localparam int DW = 16;
    localparam int FB = DW - 1;
    localparam int AW = 2 * DW + 2;

    typedef logic signed [DW-1:0]   fix_t;
    typedef logic signed [2*DW-1:0] prod_t;
    typedef logic signed [AW-1:0]   acc_t;

    typedef struct packed {
        fix_t c;
        fix_t s;
    } cplx_t;

    localparam acc_t FIX_MAX   = acc_t'((1 <<< FB) - 1);
    localparam acc_t FIX_MIN   = -acc_t'(1 <<< FB);
    localparam acc_t HALF_LSB  = acc_t'(1) <<< (FB - 1);
    localparam acc_t UNIT_WIDE = acc_t'(1) <<< (2 * FB);

    // Drop FB fraction bits from a value scaled by 2^-(2*FB), rounding to nearest, then clip to Q1.FB
    function automatic fix_t round_sat(acc_t v);
        acc_t t;
        t = (v + HALF_LSB) >>> FB;
        if (t > FIX_MAX) return fix_t'(FIX_MAX);
        if (t < FIX_MIN) return fix_t'(FIX_MIN);
        return fix_t'(t);
    endfunction

    // Elaboration-time conversion used to fill the angle tables
    function automatic int real_to_fix(real x);
        real y;
        int  r;
        y = x * (2.0 ** FB);
        if (y >= 0.0) r = $rtoi(y + 0.5);
        else          r = -$rtoi(0.5 - y);
        if (r > (1 <<< FB) - 1) r = (1 <<< FB) - 1;
        if (r < -(1 <<< FB))    r = -(1 <<< FB);
        return r;
    endfunction

    // Distance of c^2 + s^2 from 1.0, in units of 2^-(2*FB)
    function automatic longint norm_err(cplx_t w);
        longint m;
        m = longint'(w.c) * longint'(w.c) + longint'(w.s) * longint'(w.s)
            - (longint'(1) <<< (2 * FB));
        return (m < 0) ? -m : m;
    endfunction

endpackage

// File: rtl/twf_lut.sv
module twf_lut #(
    parameter int ADDR_W = 6,
    parameter int ANG_W  = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output twf_pkg::cplx_t    val
);
    localparam int  DEPTH  = 1 << ADDR_W;
    localparam real TWO_PI = 6.283185307179586;

    twf_pkg::cplx_t rom [DEPTH];

    // Entry g holds cos and sin of 2*pi*g / 2^ANG_W
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        localparam real ANG   = TWO_PI * real'(g) / (2.0 ** ANG_W);
        localparam int  COS_V = twf_pkg::real_to_fix($cos(ANG));
        localparam int  SIN_V = twf_pkg::real_to_fix($sin(ANG));
        assign rom[g] = '{c: twf_pkg::fix_t'(COS_V), s: twf_pkg::fix_t'(SIN_V)};
    end

    assign val = rom[addr];

endmodule

// File: rtl/twf_base_pe.sv
module twf_base_pe
    import twf_pkg::*;
#(
    parameter int IDX_W    = 12,
    parameter int COARSE_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IDX_W-1:0] in_idx,
    output logic             out_valid,
    output cplx_t            out_w
);
    localparam int     FINE_W   = IDX_W - COARSE_W;
    localparam longint NORM_TOL = longint'(1) <<< 19;

    cplx_t coarse_v;
    cplx_t fine_v;

    twf_lut #(.ADDR_W(COARSE_W), .ANG_W(COARSE_W)) u_coarse (
        .addr (in_idx[IDX_W-1 -: COARSE_W]),
        .val  (coarse_v)
    );

    twf_lut #(.ADDR_W(FINE_W), .ANG_W(IDX_W)) u_fine (
        .addr (in_idx[FINE_W-1:0]),
        .val  (fine_v)
    );

    typedef struct packed {
        logic  rd_vld;
        cplx_t rd_c;
        cplx_t rd_f;
        logic  mul_vld;
        prod_t cc;
        prod_t ss;
        prod_t sc;
        prod_t cs;
        logic  out_vld;
        cplx_t w;
    } base_st_t;

    base_st_t st_d, st_q;

    always_comb begin
        acc_t cos_sum;
        acc_t sin_sum;
        st_d = st_q;
        // stage 1: table read
        st_d.rd_vld  = in_valid;
        st_d.rd_c    = coarse_v;
        st_d.rd_f    = fine_v;
        // stage 2: four partial products of the angle-addition identities
        st_d.mul_vld = st_q.rd_vld;
        st_d.cc      = prod_t'(st_q.rd_c.c) * prod_t'(st_q.rd_f.c);
        st_d.ss      = prod_t'(st_q.rd_c.s) * prod_t'(st_q.rd_f.s);
        st_d.sc      = prod_t'(st_q.rd_c.s) * prod_t'(st_q.rd_f.c);
        st_d.cs      = prod_t'(st_q.rd_c.c) * prod_t'(st_q.rd_f.s);
        // stage 3: combine, round, saturate
        cos_sum      = acc_t'(st_q.cc) - acc_t'(st_q.ss);
        sin_sum      = acc_t'(st_q.sc) + acc_t'(st_q.cs);
        st_d.out_vld = st_q.mul_vld;
        st_d.w.c     = round_sat(cos_sum);
        st_d.w.s     = round_sat(sin_sum);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.out_vld;
    assign out_w     = st_q.w;

    AST_W1_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (norm_err(out_w) < NORM_TOL)); // R2

endmodule

// File: rtl/twf_recur_pe.sv
module twf_recur_pe
    import twf_pkg::*;
#(
    parameter bit TRIPLE = 1'b0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_valid,
    input  cplx_t base_w,
    input  cplx_t prev_w,
    output logic  out_valid,
    output cplx_t out_w
);
    // doubling:  c = 2*c1*c1 - 1,   s = 2*c1*s1      (prev_w = base_w)
    // tripling:  c = 2*c1*c2 - c1,  s = 2*c1*s2 - s1 (prev_w = W^2k)
    typedef struct packed {
        logic  mul_vld;
        prod_t pc;
        prod_t ps;
        cplx_t base_hold;
        logic  out_vld;
        cplx_t w;
    } rec_st_t;

    rec_st_t st_d, st_q;

    always_comb begin
        acc_t sub_c;
        acc_t sub_s;
        st_d           = st_q;
        st_d.mul_vld   = in_valid;
        st_d.pc        = prod_t'(base_w.c) * prod_t'(prev_w.c);
        st_d.ps        = prod_t'(base_w.c) * prod_t'(prev_w.s);
        st_d.base_hold = base_w;
        sub_c          = TRIPLE ? (acc_t'(st_q.base_hold.c) <<< FB) : UNIT_WIDE;
        sub_s          = TRIPLE ? (acc_t'(st_q.base_hold.s) <<< FB) : acc_t'(0);
        st_d.out_vld   = st_q.mul_vld;
        st_d.w.c       = round_sat((acc_t'(st_q.pc) <<< 1) - sub_c);
        st_d.w.s       = round_sat((acc_t'(st_q.ps) <<< 1) - sub_s);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.out_vld;
    assign out_w     = st_q.w;

    if (TRIPLE) begin : g_triple_chk
        AST_TRIPLE_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (norm_err(out_w) < (longint'(1) <<< 23))); // R4
    end else begin : g_double_chk
        AST_DOUBLE_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (norm_err(out_w) < (longint'(1) <<< 21))); // R3
    end

endmodule

// File: rtl/twf_gen.sv
module twf_gen
    import twf_pkg::*;
#(
    parameter int IDX_W    = 12,
    parameter int COARSE_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [IDX_W-1:0]     in_idx,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_w1_cos,
    output logic signed [DW-1:0] out_w1_sin,
    output logic signed [DW-1:0] out_w2_cos,
    output logic signed [DW-1:0] out_w2_sin,
    output logic signed [DW-1:0] out_w3_cos,
    output logic signed [DW-1:0] out_w3_sin
);
    localparam int BASE_LAT  = 3;
    localparam int RECUR_LAT = 2;
    localparam int LATENCY   = BASE_LAT + 2 * RECUR_LAT;
    localparam int WARM_W    = $clog2(LATENCY + 1);

    logic  base_vld, dbl_vld, tri_vld;
    cplx_t base_w, dbl_w, tri_w;

    typedef struct packed {
        cplx_t             w1_a;
        cplx_t             w1_b;
        cplx_t             w1_c;
        cplx_t             w1_d;
        cplx_t             w2_a;
        cplx_t             w2_b;
        logic [WARM_W-1:0] warm;
    } top_st_t;

    top_st_t st_d, st_q;

    twf_base_pe #(.IDX_W(IDX_W), .COARSE_W(COARSE_W)) u_base (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_idx    (in_idx),
        .out_valid (base_vld),
        .out_w     (base_w)
    );

    twf_recur_pe #(.TRIPLE(1'b0)) u_double (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (base_vld),
        .base_w    (base_w),
        .prev_w    (base_w),
        .out_valid (dbl_vld),
        .out_w     (dbl_w)
    );

    twf_recur_pe #(.TRIPLE(1'b1)) u_triple (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (dbl_vld),
        .base_w    (st_q.w1_b),
        .prev_w    (dbl_w),
        .out_valid (tri_vld),
        .out_w     (tri_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.w1_a = base_w;
        st_d.w1_b = st_q.w1_a;
        st_d.w1_c = st_q.w1_b;
        st_d.w1_d = st_q.w1_c;
        st_d.w2_a = dbl_w;
        st_d.w2_b = st_q.w2_a;
        if (st_q.warm != WARM_W'(LATENCY)) st_d.warm = st_q.warm + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = tri_vld;
    assign out_w1_cos = st_q.w1_d.c;
    assign out_w1_sin = st_q.w1_d.s;
    assign out_w2_cos = st_q.w2_b.c;
    assign out_w2_sin = st_q.w2_b.s;
    assign out_w3_cos = tri_w.c;
    assign out_w3_sin = tri_w.s;

    AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.warm == WARM_W'(LATENCY)) |-> (out_valid == $past(in_valid, 7))); // R1

    AST_IDX0_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.warm == WARM_W'(LATENCY)) && $past(in_valid, 7) && ($past(in_idx, 7) == '0))
        |-> ((out_w1_cos > 16'sd32700) && (out_w2_cos > 16'sd32700) && (out_w3_cos > 16'sd32700))); // R5

endmodule

// File: tb/twf_gen_tb_top.sv
module twf_gen_tb_top;
    localparam int  CLK_PERIOD = 10;
    localparam int  IDX_W      = 12;
    localparam int  N          = 1 << IDX_W;
    localparam int  LAT        = 7;
    localparam int  RING       = 16;
    localparam real PI         = 3.141592653589793;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [IDX_W-1:0] in_idx = '0;
    logic             out_valid;
    logic signed [15:0] w1c, w1s, w2c, w2s, w3c, w3s;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit hv [RING];
    int hk [RING];

    always #(CLK_PERIOD / 2) clk = ~clk;

    twf_gen #(.IDX_W(IDX_W), .COARSE_W(6)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_idx     (in_idx),
        .out_valid  (out_valid),
        .out_w1_cos (w1c),
        .out_w1_sin (w1s),
        .out_w2_cos (w2c),
        .out_w2_sin (w2s),
        .out_w3_cos (w3c),
        .out_w3_sin (w3s)
    );

    function automatic int ref_fix(int k, int m, bit want_sin);
        real a, y;
        int  r;
        a = 2.0 * PI * real'(m) * real'(k) / real'(N);
        y = (want_sin ? $sin(a) : $cos(a)) * 32768.0;
        if (y >= 0.0) r = $rtoi(y + 0.5);
        else          r = -$rtoi(0.5 - y);
        if (r > 32767)  r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    task automatic chk(string req, string what, int act, int exp, int tol);
        int diff;
        diff = act - exp;
        if (diff < 0) diff = -diff;
        checks++;
        if (diff > tol) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (tol %0d)", req, what, act, exp, tol);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Sample results of the index driven LAT cycles ago, then drive the next input
    task automatic step(bit v, int k);
        int  slot;
        bit  ev;
        int  ek;
        @(negedge clk);
        ev = 1'b0;
        ek = 0;
        if (cyc >= LAT) begin
            slot = (cyc - LAT) % RING;
            ev   = hv[slot];
            ek   = hk[slot];
        end
        // R1 latency, R7 bubbles
        chk(ev ? "R1 R6" : "R7", "out_valid", int'(out_valid), int'(ev), 0);
        if (ev && out_valid) begin
            chk("R2 R8", $sformatf("w1 cos k=%0d", ek), int'(w1c), ref_fix(ek, 1, 1'b0), 3);
            chk("R2 R8", $sformatf("w1 sin k=%0d", ek), int'(w1s), ref_fix(ek, 1, 1'b1), 3);
            chk("R3 R6", $sformatf("w2 cos k=%0d", ek), int'(w2c), ref_fix(ek, 2, 1'b0), 12);
            chk("R3 R6", $sformatf("w2 sin k=%0d", ek), int'(w2s), ref_fix(ek, 2, 1'b1), 12);
            chk("R4 R6", $sformatf("w3 cos k=%0d", ek), int'(w3c), ref_fix(ek, 3, 1'b0), 32);
            chk("R4 R6", $sformatf("w3 sin k=%0d", ek), int'(w3s), ref_fix(ek, 3, 1'b1), 32);
            if (ek == 0) begin
                // R5: no wrap near +1.0
                chk("R5", "w1 cos above 32700", int'(w1c > 16'sd32700), 1, 0);
                chk("R5", "w2 cos above 32700", int'(w2c > 16'sd32700), 1, 0);
                chk("R5", "w3 cos above 32700", int'(w3c > 16'sd32700), 1, 0);
            end
        end
        in_valid       = v;
        in_idx         = IDX_W'(k);
        hv[cyc % RING] = v;
        hk[cyc % RING] = k;
        cyc++;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "out_valid in reset", int'(out_valid), 0, 0);
        chk("R1", "w1 cos in reset", int'(w1c), 0, 0);
        rst_n = 1'b1;
        // R5 R8 directed corners, back-to-back (R6)
        step(1'b1, 0);
        step(1'b1, N / 4);
        step(1'b1, N / 2);
        step(1'b1, 3 * N / 4);
        step(1'b1, 63);
        step(1'b1, 64);
        step(1'b1, 4032);
        step(1'b1, N - 1);
        step(1'b1, 0);
        // R7: bubbles carrying junk indices
        for (int i = 0; i < 10; i++) step(i[0], (i * 517) % N);
        // seeded random mix
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3000; i++) begin
            int k;
            bit v;
            k = int'($urandom_range(N - 1, 0));
            v = ($urandom_range(3, 0) != 0);
            step(v, k);
        end
        for (int i = 0; i < LAT + 3; i++) step(1'b0, 0);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog: actual %0d cycles expected completion", cyc);
            summary();
            $finish;
        end
    end

endmodule